// File: doc/BRIEF.md
# Dual Socket Memory Window Decoder

This block sits between a 20-bit processor memory address bus and two byte-wide memory sockets. Each socket has a two-bit window code and can be switched off or made visible through one of three windows in the upper memory area. A 64K window can sit at the D segment or at the E segment, and a 128K window can span both. Each socket also has a separate enable bit. Because the windows may overlap, the decoder gives socket 0 priority over socket 1.

Each socket has a page register, so the window size does not limit the size of the device behind it. The device address combines the selected socket's page number with the offset of the access inside its window. A larger part is therefore seen one 64K or 128K page at a time. A small write port loads the window codes, the enable bits and the page numbers. At reset, the window codes and enable bits take their values from default pins, and both page numbers clear.

Top module: `umb_socket_decoder`

## Requirements
- R1: Window code 2'b00 matches no address. 2'b01 matches 20'hD0000 to 20'hDFFFF. 2'b10 matches 20'hE0000 to 20'hEFFFF. 2'b11 matches 20'hD0000 to 20'hEFFFF. No code matches an address outside its range.
- R2: A socket whose enable bit is 0 never raises its select line, whatever the address. Enable bit 0 of the register belongs to socket 0 and bit 1 belongs to socket 1.
- R3: When an address falls inside the windows of both enabled sockets, only `sel[0]` is raised. Socket 1 answers at that address once socket 0 is disabled.
- R4: A select line is raised only while `mem_rd` or `mem_wr` is high. With both strobes low, `sel` is 2'b00.
- R5: For a 64K window (code 01 or 10), `dev_addr` is {1'b0, page, addr[15:0]}, taken from the selected socket.
- R6: For a 128K window (code 11), `dev_addr` is {page, (addr - 20'hD0000)[16:0]}, taken from the selected socket.
- R7: When no socket is selected, `dev_addr` is zero.
- R8: On reset, the window codes load from `dflt_win0` and `dflt_win1`, the enable bits load from `dflt_en`, and both page registers clear to 0.
- R9: Register map while `reg_we` is high. Address 0 writes `reg_wdata[1:0]` to the socket 0 window code. Address 1 writes `reg_wdata[1:0]` to the socket 1 window code. Address 2 writes `reg_wdata[1:0]` to the enable bits. Address 3 writes `reg_wdata[3:0]` to the socket 0 page and `reg_wdata[7:4]` to the socket 1 page.
- R10: A register write takes effect at the next rising clock edge. A decode in the same cycle as the write still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | 20 | Processor memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| dflt_win0 | input | 2 | Reset value of socket 0 window code |
| dflt_win1 | input | 2 | Reset value of socket 1 window code |
| dflt_en | input | 2 | Reset value of the enable bits |
| sel | output | 2 | Per-socket select, active high |
| dev_addr | output | 21 | Device address of the selected socket |

## Verification
The embedded assertions check the following on every clock:
- at most one select is high;
- socket 1 never wins an address that enabled socket 0 also claims;
- no select is raised without a strobe or on a disabled socket;
- the device address is zero when nothing is selected;
- every hit lies in the D or E segment;
- each register write shows up one edge later.

Only the bench's scenarios can show the rest:
- the exact window boundaries;
- the page and offset arithmetic for both window sizes;
- the reset defaults;
- that a decode in the same cycle as a write still sees the old configuration.

// File: rtl/umb_win_pkg.sv
package umb_win_pkg;

  typedef enum logic [1:0] {
    WIN_OFF   = 2'b00,
    WIN_D64   = 2'b01,
    WIN_E64   = 2'b10,
    WIN_DE128 = 2'b11
  } win_code_e;

  localparam logic [3:0] SEG_D = 4'hD;
  localparam logic [3:0] SEG_E = 4'hE;

  // Does a window code cover the 64K segment named by the top address nibble?
  function automatic logic seg_in_window(input win_code_e code, input logic [3:0] seg);
    unique case (code)
      WIN_D64:   seg_in_window = (seg == SEG_D);
      WIN_E64:   seg_in_window = (seg == SEG_E);
      WIN_DE128: seg_in_window = (seg == SEG_D) || (seg == SEG_E);
      default:   seg_in_window = 1'b0;
    endcase
  endfunction

  // Offset inside the window. For the 128K window, D maps to 0 and E maps to 1
  // in bit 16, which is address bit 17 inside the window.
  function automatic logic [16:0] window_offset(input win_code_e code, input logic [19:0] a);
    if (code == WIN_DE128) window_offset = {a[17], a[15:0]};
    else                   window_offset = {1'b0, a[15:0]};
  endfunction

endpackage

// File: rtl/umb_win_match.sv
module umb_win_match
  import umb_win_pkg::*;
(
  input  win_code_e   code,
  input  logic [19:0] addr,
  output logic        hit,
  output logic [16:0] offset
);

  assign hit    = seg_in_window(code, addr[19:16]);
  assign offset = window_offset(code, addr);

  always_comb begin
    if (hit) assert_hit_in_umb_R1: assert ((addr[19:16] == SEG_D) || (addr[19:16] == SEG_E));
  end

endmodule

// File: rtl/umb_cfg_regs.sv
module umb_cfg_regs
  import umb_win_pkg::*;
#(
  parameter int NSOCK  = 2,
  parameter int PAGE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [1:0]                    reg_addr,
  input  logic [NSOCK*PAGE_W-1:0]       reg_wdata,
  input  logic [NSOCK-1:0][1:0]         dflt_win,
  input  logic [NSOCK-1:0]              dflt_en,
  output win_code_e [NSOCK-1:0]         win_q,
  output logic [NSOCK-1:0]              en_q,
  output logic [NSOCK-1:0][PAGE_W-1:0]  page_q
);

  localparam logic [1:0] A_WIN0 = 2'd0;
  localparam logic [1:0] A_WIN1 = 2'd1;
  localparam logic [1:0] A_EN   = 2'd2;
  localparam logic [1:0] A_PAGE = 2'd3;

  logic wr_win0, wr_win1, wr_en, wr_page;
  assign wr_win0 = reg_we && (reg_addr == A_WIN0);
  assign wr_win1 = reg_we && (reg_addr == A_WIN1);
  assign wr_en   = reg_we && (reg_addr == A_EN);
  assign wr_page = reg_we && (reg_addr == A_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSOCK; s++) begin
        win_q[s]  <= win_code_e'(dflt_win[s]);
        page_q[s] <= '0;
      end
      en_q <= dflt_en;
    end else begin
      if (wr_win0) win_q[0] <= win_code_e'(reg_wdata[1:0]);
      if (wr_win1) win_q[1] <= win_code_e'(reg_wdata[1:0]);
      if (wr_en)   en_q     <= reg_wdata[NSOCK-1:0];
      if (wr_page) begin
        for (int s = 0; s < NSOCK; s++) page_q[s] <= reg_wdata[s*PAGE_W +: PAGE_W];
      end
    end
  end

  assert_en_write_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(reg_wdata[NSOCK-1:0]));
  assert_page_write_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page |=> page_q[0] == $past(reg_wdata[PAGE_W-1:0]));
  assert_win_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_win0 |=> $stable(win_q[0]));

endmodule

// File: rtl/umb_socket_decoder.sv
module umb_socket_decoder
  import umb_win_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [19:0]           mem_addr,
  input  logic                  mem_rd,
  input  logic                  mem_wr,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [2*PAGE_W-1:0]   reg_wdata,
  input  logic [1:0]            dflt_win0,
  input  logic [1:0]            dflt_win1,
  input  logic [1:0]            dflt_en,
  output logic [1:0]            sel,
  output logic [PAGE_W+16:0]    dev_addr
);

  localparam int NSOCK = 2;
  localparam int DEV_W = PAGE_W + 17;

  win_code_e [NSOCK-1:0]         win_q;
  logic [NSOCK-1:0]              en_q;
  logic [NSOCK-1:0][PAGE_W-1:0]  page_q;
  logic [NSOCK-1:0]              hit_raw;
  logic [NSOCK-1:0][16:0]        off;
  logic [NSOCK-1:0]              want;
  logic                          strobe;

  assign strobe = mem_rd | mem_wr;

  umb_cfg_regs #(.NSOCK(NSOCK), .PAGE_W(PAGE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .dflt_win ({dflt_win1, dflt_win0}),
    .dflt_en  (dflt_en),
    .win_q    (win_q),
    .en_q     (en_q),
    .page_q   (page_q)
  );

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    umb_win_match u_match (
      .code  (win_q[s]),
      .addr  (mem_addr),
      .hit   (hit_raw[s]),
      .offset(off[s])
    );
    assign want[s] = strobe & en_q[s] & hit_raw[s];

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[s] |-> !sel[s]);
  end

  // 64K window: the page sits above a 16-bit offset. 128K window: above 17 bits.
  function automatic logic [DEV_W-1:0] form_dev(input win_code_e code,
                                                input logic [PAGE_W-1:0] page,
                                                input logic [16:0] offset);
    if (code == WIN_DE128) form_dev = {page, offset};
    else                   form_dev = {1'b0, page, offset[15:0]};
  endfunction

  // Fixed priority: the lowest-numbered wanting socket wins.
  always_comb begin
    logic taken;
    taken    = 1'b0;
    sel      = '0;
    dev_addr = '0;
    for (int s = 0; s < NSOCK; s++) begin
      if (want[s] && !taken) begin
        sel[s]   = 1'b1;
        dev_addr = form_dev(win_q[s], page_q[s], off[s]);
        taken    = 1'b1;
      end
    end
  end

  assert_single_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_socket0_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && en_q[0] && hit_raw[0]) |-> !sel[1]);
  assert_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |-> (sel == 2'b00));
  assert_idle_dev_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |-> (dev_addr == '0));

endmodule

// File: tb/sim_umb_socket_decoder.sv
`timescale 1ns/1ps
module sim_umb_socket_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [1:0]  dflt_win0 = 2'b11, dflt_win1 = 2'b01, dflt_en = 2'b01;
  logic [1:0]  sel;
  logic [20:0] dev_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  umb_socket_decoder u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dflt_win0(dflt_win0), .dflt_win1(dflt_win1), .dflt_en(dflt_en),
    .sel(sel), .dev_addr(dev_addr)
  );

  // fields: win0, win1, en, page0, page1, addr, rd, wr, expected sel
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {2'b01, 2'b10, 2'b11, 4'h2, 4'h7, 20'hD1234, 1'b1, 1'b0, 2'b01},
    {2'b01, 2'b10, 2'b11, 4'h2, 4'h7, 20'hE1234, 1'b1, 1'b0, 2'b10},
    {2'b01, 2'b10, 2'b11, 4'h2, 4'h7, 20'hC1234, 1'b1, 1'b0, 2'b00},
    {2'b11, 2'b01, 2'b11, 4'h3, 4'h1, 20'hD0005, 1'b0, 1'b1, 2'b01},
    {2'b11, 2'b01, 2'b01, 4'h3, 4'h1, 20'hE0005, 1'b1, 1'b0, 2'b01},
    {2'b11, 2'b01, 2'b10, 4'h3, 4'h1, 20'hD0005, 1'b1, 1'b0, 2'b10},
    {2'b11, 2'b01, 2'b11, 4'h3, 4'h1, 20'hD0005, 1'b0, 1'b0, 2'b00},
    {2'b00, 2'b11, 2'b11, 4'h9, 4'h5, 20'hEFFFF, 1'b1, 1'b0, 2'b10},
    {2'b10, 2'b00, 2'b11, 4'h4, 4'h0, 20'hF0000, 1'b1, 1'b0, 2'b00},
    {2'b10, 2'b10, 2'b11, 4'h4, 4'h6, 20'hEABCD, 1'b0, 1'b1, 2'b01},
    {2'b01, 2'b01, 2'b00, 4'h1, 4'h1, 20'hD0000, 1'b1, 1'b0, 2'b00},
    {2'b11, 2'b11, 2'b10, 4'h0, 4'hF, 20'hEFFFF, 1'b1, 1'b0, 2'b10},
    {2'b00, 2'b00, 2'b11, 4'hA, 4'hB, 20'hD8000, 1'b1, 1'b1, 2'b00}
  };

  function automatic logic [20:0] model_dev(input logic [1:0] w, input logic [3:0] p,
                                            input logic [19:0] a);
    logic [19:0] rel;
    rel = a - 20'hD0000;
    if (w == 2'b11) return {p, rel[16:0]};
    return {1'b0, p, a[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: defaults socket0 = 128K, socket1 = D 64K, only socket 0 enabled, pages 0
    mem_addr = 20'hE0010; mem_rd = 1'b1; #1;
    check("R8 reset sel", 32'(sel), 32'h1);
    check("R8 reset page0 dev", 32'(dev_addr), 32'h10010);
    mem_addr = 20'hD0020; #1;
    check("R8 reset sel D overlap", 32'(sel), 32'h1);
    check("R8 reset dev", 32'(dev_addr), 32'h00020);

    // R10: write enables to 00; same-cycle decode still uses old values
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00; #1;
    check("R10 old value before edge", 32'(sel), 32'h1);
    @(posedge clk); #1;
    reg_we = 1'b0;
    check("R10 new value after edge", 32'(sel), 32'h0);
    check("R7 idle dev zero", 32'(dev_addr), 32'h0);

    // R2: socket 1 disabled while socket 0 off too -> still nothing
    mem_addr = 20'hD4444; #1;
    check("R2 disabled sockets", 32'(sel), 32'h0);
    mem_rd = 1'b0;

    // R1, R3, R4, R5, R6, R9: vector walk, configured through the register port
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      logic [1:0] exp_sel;
      logic [20:0] exp_dev;
      v = VEC[i];
      wr_reg(2'd0, {6'b0, v[37:36]});
      wr_reg(2'd1, {6'b0, v[35:34]});
      wr_reg(2'd2, {6'b0, v[33:32]});
      wr_reg(2'd3, {v[27:24], v[31:28]});
      mem_addr = v[23:4]; mem_rd = v[3]; mem_wr = v[2]; #1;
      exp_sel = v[1:0];
      if (exp_sel == 2'b01)      exp_dev = model_dev(v[37:36], v[31:28], v[23:4]);
      else if (exp_sel == 2'b10) exp_dev = model_dev(v[35:34], v[27:24], v[23:4]);
      else                       exp_dev = '0;
      check($sformatf("R1/R2/R3/R4 sel vec %0d", i), 32'(sel), 32'(exp_sel));
      check($sformatf("R5/R6/R7 dev vec %0d", i), 32'(dev_addr), 32'(exp_dev));
      mem_rd = 1'b0; mem_wr = 1'b0;
    end

    // R1 boundaries of the 128K window, R6 offset at the top edge
    wr_reg(2'd0, 8'h03); wr_reg(2'd2, 8'h01); wr_reg(2'd3, 8'h0C);
    mem_rd = 1'b1;
    mem_addr = 20'hCFFFF; #1;
    check("R1 below window", 32'(sel), 32'h0);
    mem_addr = 20'hF0000; #1;
    check("R1 above window", 32'(sel), 32'h0);
    mem_addr = 20'hD0000; #1;
    check("R6 low edge dev", 32'(dev_addr), 32'(21'h180000));
    mem_addr = 20'hEFFFF; #1;
    check("R6 high edge dev", 32'(dev_addr), 32'(21'h19FFFF));
    mem_rd = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule